// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned or two's-complement words and a carry-in in a single combinational pass. It produces a sum of the same width and a carry-out. Per-bit generate and propagate terms are formed first. A tree of identical combine cells then turns them into group terms that span every bit from position zero up to each position. Each carry follows from its group terms and the carry-in, and the sum bits are formed last.

A parameter chooses the shape of the combine tree, and the choice trades logic depth against cell count. The minimum-depth shape fans every position out at distances 1, 2, 4 and so on. The minimum-cell shape does an up-sweep and then a down-sweep over a binary tree. The hybrid shape first pairs neighbours, then runs the minimum-depth tree over the odd positions only, and ends with one fix-up level for the even positions. All three shapes must produce the same bits. The block has no clock and no state, so a surrounding pipeline can place it between any two register stages.

Top module: `prefix_adder`

## Requirements
- R1: For every operand pair and carry-in, `{carry_out, sum}` equals `opa + opb + carry_in`, taken as a (WIDTH+1)-bit unsigned sum. This holds for WIDTH 8 and 16.
- R2: TOPOLOGY values 0 (minimum depth), 1 (minimum cell count) and 2 (hybrid) give bit-identical `sum` and `carry_out` for the same inputs.
- R3: With `opa` all ones, `opb` zero and `carry_in` 1, the carry crosses every position: `sum` is zero and `carry_out` is 1.
- R4: When `opa ^ opb` is all ones, so that every position propagates, `carry_out` equals `carry_in` and every `sum` bit equals the inverse of `carry_in`.
- R5: With both operands zero, `sum` equals `carry_in` in bit 0 and zero elsewhere, and `carry_out` is 0.
- R6: If both most significant operand bits are 1, `carry_out` is 1. If both are 0, `carry_out` is 0.
- R7: `sum[0]` equals `opa[0] ^ opb[0] ^ carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First addend |
| opb | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds each of the three tree shapes twice: once at WIDTH 8 and once at the default WIDTH 16. At WIDTH 8 every operand pair is applied with both carry-in values, so every carry chain that can occur is exercised on every shape and the shapes are compared with each other. The WIDTH 16 copies receive patterns derived from that sweep, random words, and the named corner cases: a full-length carry, all positions propagating, zero operands, and generate or kill at the top bit.

// File: rtl/prefix_pkg.sv
// Shared types and the single combine cell used by every prefix tree.
// Assumes callers keep the higher-order block first: the cell is not commutative.
package prefix_pkg;

    typedef enum int {
        TOPO_MIN_DEPTH = 0,
        TOPO_MIN_CELL  = 1,
        TOPO_HYBRID    = 2
    } topo_e;

    // Merge a lower block (g_lo,p_lo) into a higher block (g_hi,p_hi); returns {g,p}.
    function automatic logic [1:0] pfx_combine(input logic g_hi, input logic p_hi,
                                               input logic g_lo, input logic p_lo);
        return {g_hi | (p_hi & g_lo), p_hi & p_lo};
    endfunction

endpackage

// File: rtl/pfx_bitgen.sv
// Forms per-bit generate (both bits set) and propagate (bits differ) terms.
// Assumes nothing beyond equal-width operands.
module pfx_bitgen #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o
);
    // Bitwise generate and propagate.
    assign gen_o  = opa & opb;
    assign prop_o = opa ^ opb;
endmodule

// File: rtl/prefix_net.sv
// Computes for every position i the group generate/propagate over bits 0..i.
// TOPOLOGY picks the tree shape; WIDTH must be a power of two of at least 4.
module prefix_net
    import prefix_pkg::*;
#(
    parameter int    WIDTH    = 16,
    parameter topo_e TOPOLOGY = TOPO_MIN_DEPTH
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] prop_i,
    output logic [WIDTH-1:0] grp_g_o,
    output logic [WIDTH-1:0] grp_p_o
);
    localparam int LG = $clog2(WIDTH);

    if (WIDTH < 4 || (1 << LG) != WIDTH) begin : g_bad_width
        $error("prefix_net: WIDTH must be a power of two, at least 4");
    end

    if (TOPOLOGY == TOPO_MIN_DEPTH) begin : g_min_depth
        // LG levels; at level l every position at or above 2^l takes the one 2^l below.
        logic [LG:0][WIDTH-1:0] gs, ps;
        assign gs[0] = gen_i;
        assign ps[0] = prop_i;
        for (genvar l = 0; l < LG; l++) begin : g_lvl
            localparam int D = 1 << l;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                if (i >= D) begin : g_cell
                    assign {gs[l+1][i], ps[l+1][i]} =
                        pfx_combine(gs[l][i], ps[l][i], gs[l][i-D], ps[l][i-D]);
                end else begin : g_pass
                    assign gs[l+1][i] = gs[l][i];
                    assign ps[l+1][i] = ps[l][i];
                end
            end
        end
        assign grp_g_o = gs[LG];
        assign grp_p_o = ps[LG];
    end else if (TOPOLOGY == TOPO_MIN_CELL) begin : g_min_cell
        // Up-sweep over LG levels, then down-sweep over LG-1 levels.
        localparam int NL = 2 * LG - 1;
        logic [NL:0][WIDTH-1:0] gs, ps;
        assign gs[0] = gen_i;
        assign ps[0] = prop_i;
        for (genvar l = 0; l < NL; l++) begin : g_lvl
            localparam int D  = (l < LG) ? (1 << l) : (1 << (2 * LG - 2 - l));
            localparam bit UP = (l < LG);
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                if (UP ? (((i + 1) % (2 * D)) == 0)
                       : ((((i + 1) % (2 * D)) == D) && (i + 1 > D))) begin : g_cell
                    assign {gs[l+1][i], ps[l+1][i]} =
                        pfx_combine(gs[l][i], ps[l][i], gs[l][i-D], ps[l][i-D]);
                end else begin : g_pass
                    assign gs[l+1][i] = gs[l][i];
                    assign ps[l+1][i] = ps[l][i];
                end
            end
        end
        assign grp_g_o = gs[NL];
        assign grp_p_o = ps[NL];
    end else begin : g_hybrid
        // Pair neighbours, run the min-depth tree over odd positions, then fix even ones.
        localparam int NL = LG + 1;
        logic [NL:0][WIDTH-1:0] gs, ps;
        assign gs[0] = gen_i;
        assign ps[0] = prop_i;
        for (genvar l = 0; l < NL; l++) begin : g_lvl
            localparam int D = (l == 0 || l == LG) ? 1 : (1 << l);
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                if ((l == 0)  ? (i % 2 == 1) :
                    (l == LG) ? ((i % 2 == 0) && (i >= 2)) :
                                ((i % 2 == 1) && (i >= D))) begin : g_cell
                    assign {gs[l+1][i], ps[l+1][i]} =
                        pfx_combine(gs[l][i], ps[l][i], gs[l][i-D], ps[l][i-D]);
                end else begin : g_pass
                    assign gs[l+1][i] = gs[l][i];
                    assign ps[l+1][i] = ps[l][i];
                end
            end
        end
        assign grp_g_o = gs[NL];
        assign grp_p_o = ps[NL];
    end
endmodule

// File: rtl/pfx_sumgen.sv
// Turns group terms and the carry-in into carries, sum bits and carry-out.
// Assumes grp_*_i[i] covers bits 0..i with the carry-in left out.
module pfx_sumgen #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] grp_g_i,
    input  logic [WIDTH-1:0] grp_p_i,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    logic [WIDTH:0] carry;

    // Carry into position i+1 is the group generate, or the carry-in passed through the group.
    assign carry[0]       = carry_in;
    assign carry[WIDTH:1] = grp_g_i | (grp_p_i & {WIDTH{carry_in}});

    // Sum bits and final carry.
    assign sum       = prop_i ^ carry[WIDTH-1:0];
    assign carry_out = carry[WIDTH];
endmodule

// File: rtl/prefix_adder.sv
// Top: combinational WIDTH-bit adder with a selectable parallel-prefix carry tree.
// Assumes WIDTH is a power of two of at least 4; holds no state.
module prefix_adder
    import prefix_pkg::*;
#(
    parameter int    WIDTH    = 16,
    parameter topo_e TOPOLOGY = TOPO_MIN_DEPTH
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    logic [WIDTH-1:0] gen, prop, grp_g, grp_p;

    pfx_bitgen #(.WIDTH(WIDTH)) u_bitgen (
        .opa    (opa),
        .opb    (opb),
        .gen_o  (gen),
        .prop_o (prop)
    );

    prefix_net #(.WIDTH(WIDTH), .TOPOLOGY(TOPOLOGY)) u_net (
        .gen_i   (gen),
        .prop_i  (prop),
        .grp_g_o (grp_g),
        .grp_p_o (grp_p)
    );

    pfx_sumgen #(.WIDTH(WIDTH)) u_sumgen (
        .prop_i    (prop),
        .grp_g_i   (grp_g),
        .grp_p_i   (grp_p),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out)
    );
endmodule

// File: rtl/prefix_adder_chk.sv
// Checker for prefix_adder: port-level relations that every tree shape must meet.
// Assumes the observed block is combinational, so immediate checks are used.
module prefix_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);
    // Arithmetic and corner relations between inputs and outputs.
    always_comb begin
        p_exact_sum_r1: assert ({carry_out, sum} ==
            ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in}))
            else $error("R1 sum mismatch");
        if ((&opa) && (opb == '0) && carry_in)
            p_full_chain_r3: assert ((sum == '0) && carry_out)
                else $error("R3 full carry chain");
        if (&(opa ^ opb))
            p_all_prop_r4: assert ((carry_out == carry_in) && (sum == {WIDTH{~carry_in}}))
                else $error("R4 all propagate");
        if ((opa == '0) && (opb == '0))
            p_zero_ops_r5: assert (!carry_out && (sum == {{(WIDTH-1){1'b0}}, carry_in}))
                else $error("R5 zero operands");
        if (opa[WIDTH-1] && opb[WIDTH-1])
            p_top_gen_r6: assert (carry_out) else $error("R6 top generate");
        if (!opa[WIDTH-1] && !opb[WIDTH-1])
            p_top_kill_r6: assert (!carry_out) else $error("R6 top kill");
        p_lsb_r7: assert (sum[0] == (opa[0] ^ opb[0] ^ carry_in))
            else $error("R7 low bit");
    end
endmodule

bind prefix_adder prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/prefix_adder_bench.sv
`timescale 1ns/1ps
// Bench: exhaustive 8-bit sweep of all three tree shapes, then 16-bit corners and random words.
module prefix_adder_bench;
    import prefix_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    logic [7:0]  a8, b8;
    logic        c8;
    logic [7:0]  s8_md, s8_mc, s8_hy;
    logic        co8_md, co8_mc, co8_hy;
    logic [15:0] a16, b16;
    logic        c16;
    logic [15:0] s16_md, s16_mc, s16_hy;
    logic        co16_md, co16_mc, co16_hy;

    prefix_adder #(.WIDTH(8), .TOPOLOGY(TOPO_MIN_DEPTH)) u8_md (
        .opa(a8), .opb(b8), .carry_in(c8), .sum(s8_md), .carry_out(co8_md));
    prefix_adder #(.WIDTH(8), .TOPOLOGY(TOPO_MIN_CELL)) u8_mc (
        .opa(a8), .opb(b8), .carry_in(c8), .sum(s8_mc), .carry_out(co8_mc));
    prefix_adder #(.WIDTH(8), .TOPOLOGY(TOPO_HYBRID)) u8_hy (
        .opa(a8), .opb(b8), .carry_in(c8), .sum(s8_hy), .carry_out(co8_hy));
    prefix_adder u_prefix_adder (
        .opa(a16), .opb(b16), .carry_in(c16), .sum(s16_md), .carry_out(co16_md));
    prefix_adder #(.WIDTH(16), .TOPOLOGY(TOPO_MIN_CELL)) u16_mc (
        .opa(a16), .opb(b16), .carry_in(c16), .sum(s16_mc), .carry_out(co16_mc));
    prefix_adder #(.WIDTH(16), .TOPOLOGY(TOPO_HYBRID)) u16_hy (
        .opa(a16), .opb(b16), .carry_in(c16), .sum(s16_hy), .carry_out(co16_hy));

    // Compare one value and report a mismatch.
    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check all 16-bit copies against arithmetic and against each other.
    task automatic check16(input string tag);
        logic [16:0] exp;
        exp = {1'b0, a16} + {1'b0, b16} + {16'd0, c16};
        chk({tag, " R1 min-depth"}, {co16_md, s16_md}, exp);
        chk({tag, " R1 min-cell"},  {co16_mc, s16_mc}, exp);
        chk({tag, " R1 hybrid"},    {co16_hy, s16_hy}, exp);
        chk({tag, " R2 min-cell vs min-depth"}, {co16_mc, s16_mc}, {co16_md, s16_md});
        chk({tag, " R2 hybrid vs min-depth"},   {co16_hy, s16_hy}, {co16_md, s16_md});
    endtask

    // Apply one 16-bit vector and check it together with a stated expectation.
    task automatic vec16(input string tag, input logic [15:0] a, input logic [15:0] b,
                         input logic c, input logic [16:0] exp);
        @(posedge clk);
        a16 = a; b16 = b; c16 = c;
        @(negedge clk);
        check16(tag);
        chk({tag, " stated value"}, {co16_md, s16_md}, exp);
        chk({tag, " stated value hybrid"}, {co16_hy, s16_hy}, exp);
        chk({tag, " stated value min-cell"}, {co16_mc, s16_mc}, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [16:0] e8;
        a8 = '0; b8 = '0; c8 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Initial state: zero inputs, zero outputs (R5).
        chk("R5 initial 16-bit", {co16_md, s16_md}, 17'd0);
        chk("R5 initial 8-bit",  {8'd0, co8_md, s8_md}, 17'd0);

        // Named corners at 16 bits.
        vec16("R5 zero ops cin1", 16'h0000, 16'h0000, 1'b1, 17'h00001);
        vec16("R3 full chain",    16'hFFFF, 16'h0000, 1'b1, 17'h10000);
        vec16("R3 ones plus ones", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);
        vec16("R4 propagate cin0", 16'hF0F0, 16'h0F0F, 1'b0, 17'h0FFFF);
        vec16("R4 propagate cin1", 16'hA5A5, 16'h5A5A, 1'b1, 17'h10000);
        vec16("R6 top generate",  16'h8000, 16'h8000, 1'b0, 17'h10000);
        vec16("R6 top kill",      16'h7FFF, 16'h0000, 1'b1, 17'h08000);
        vec16("R7 low bit",       16'h0001, 16'h0000, 1'b1, 17'h00002);

        // Random 16-bit words.
        for (int n = 0; n < 2000; n++) begin
            @(posedge clk);
            a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
            @(negedge clk);
            check16("random");
        end

        // Exhaustive 8-bit sweep; 16-bit copies get derived patterns alongside.
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    @(posedge clk);
                    a8 = 8'(a); b8 = 8'(b); c8 = 1'(c);
                    a16 = {8'(b), 8'(a)} ^ 16'hA5C3;
                    b16 = {8'(a ^ b), 8'(b)};
                    c16 = 1'(c);
                    @(negedge clk);
                    e8 = 17'(a + b + c);
                    chk("R1 sweep8 min-depth", {8'd0, co8_md, s8_md}, e8);
                    chk("R1 sweep8 min-cell",  {8'd0, co8_mc, s8_mc}, e8);
                    chk("R1 sweep8 hybrid",    {8'd0, co8_hy, s8_hy}, e8);
                    chk("R7 sweep8 low bit", {16'd0, s8_hy[0]}, {16'd0, 1'(a ^ b ^ c)});
                    chk("R2 sweep8 variants", {8'd0, co8_mc, s8_mc}, {8'd0, co8_hy, s8_hy});
                    check16("sweep16");
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule